// File: doc/BRIEF.md
# Effective Address Generator for Pointer, Base and Indexed Operands

This block turns an operand addressing request into a 16-bit memory address. A request carries a mode, a selector and a snapshot of the register file: the 8-bit registers A and B, the 16-bit pairs DE, HL and SP, an 8-bit displacement and a 16-bit base word. The base word arrives as two bytes, because an instruction stream delivers it low byte first. The result appears on registered outputs one clock after the request.

Pointer modes may step the pair they use. The address is always the pair's value before the step. The stepped value comes back, with a one-cycle enable and a flag that names the pair, so the register file can store it. Selector codes with no defined meaning set a flag instead of producing an address. The memory access and the fetch of displacement or base bytes are done by the surrounding logic.

Top module: `eag_top`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `rspValid`, `invalidSel`, `wbEn`, `wbPairHl`, `effAddr` and `wbValue` are all zero.
- R2: A request sampled with `reqValid` high at a rising edge gives its result on the outputs after that edge, with `rspValid` high. After an edge where `reqValid` is low, `rspValid`, `wbEn` and `invalidSel` are low.
- R3: In pointer mode (`reqMode` = 0), selector 4 gives DE and selector 5 gives HL as `effAddr`, with `wbEn` low.
- R4: In pointer mode, selectors 0 (DE, step up), 1 (HL, step up), 2 (DE, step down) and 3 (HL, step down) give the old pair value as `effAddr`. They raise `wbEn` for one cycle, set `wbPairHl` (0 = DE, 1 = HL) and return the old value plus or minus one, modulo 2^16, on `wbValue`. For every other request `wbEn`, `wbPairHl` and `wbValue` are zero.
- R5: In base mode (`reqMode` = 1), `effAddr` is the zero-extended `disp` added to DE (selector 0), SP (selector 1) or HL (selector 2), modulo 2^16.
- R6: In indexed mode (`reqMode` = 2), `effAddr` is `{baseHi, baseLo}` plus DE (selector 0), zero-extended A (1), HL (2) or zero-extended B (3), modulo 2^16.
- R7: Pointer selectors 6 and 7, base selector 3 and the reserved mode 3 raise `invalidSel`, force `effAddr` to zero and keep `wbEn` low.
- R8: In base and indexed modes only `reqSel[1:0]` is decoded. Selector bit 2 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqMode | input | 2 | 0 pointer, 1 base, 2 indexed, 3 reserved |
| reqSel | input | 3 | Register selector |
| regA | input | 8 | Register A |
| regB | input | 8 | Register B |
| regDE | input | 16 | Pair D:E |
| regHL | input | 16 | Pair H:L |
| regSP | input | 16 | Stack pointer |
| disp | input | 8 | Base-mode displacement |
| baseLo | input | 8 | Low byte of the indexed base word |
| baseHi | input | 8 | High byte of the indexed base word |
| rspValid | output | 1 | Result valid |
| effAddr | output | 16 | Effective address |
| invalidSel | output | 1 | Undefined mode or selector |
| wbEn | output | 1 | Pointer write-back enable |
| wbPairHl | output | 1 | Write-back target: 0 DE, 1 HL |
| wbValue | output | 16 | Stepped pointer value |

## Verification
The address and the pointer write-back leave the block in the same cycle. One is the old pair value and the other is that value stepped. The bench sets DE and HL to 0x0000 and 0xFFFF to drive both steps across the wrap, and runs requests back to back with idle cycles in between. Each output cycle is judged on all six result fields against values computed in the bench, so a stepped value shown as the address, or a late enable, is caught.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [1:0] {
    MODE_PTR   = 2'd0,
    MODE_BASE  = 2'd1,
    MODE_INDEX = 2'd2,
    MODE_RSVD  = 2'd3
  } eaMode_e;

  typedef enum logic [1:0] {
    BASE_DE,
    BASE_HL,
    BASE_SP,
    BASE_WORD
  } baseSrc_e;

  typedef enum logic [2:0] {
    ADD_ZERO,
    ADD_DISP,
    ADD_A,
    ADD_B,
    ADD_DE,
    ADD_HL
  } addSrc_e;

  typedef enum logic [1:0] {
    STEP_NONE,
    STEP_INC,
    STEP_DEC
  } step_e;

  typedef struct packed {
    baseSrc_e baseSrc;
    addSrc_e  addSrc;
    step_e    step;
    logic     wbToHl;
    logic     invalid;
  } eaStrobes_t;

endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic [1:0] reqMode,
  input  logic [2:0] reqSel,
  output eaStrobes_t strobes
);

  always_comb begin
    strobes = '{baseSrc: BASE_DE, addSrc: ADD_ZERO, step: STEP_NONE,
                wbToHl: 1'b0, invalid: 1'b0};
    unique case (eaMode_e'(reqMode))
      MODE_PTR: begin
        unique case (reqSel)
          3'd0: strobes.step = STEP_INC;
          3'd1: begin strobes.baseSrc = BASE_HL; strobes.step = STEP_INC; strobes.wbToHl = 1'b1; end
          3'd2: strobes.step = STEP_DEC;
          3'd3: begin strobes.baseSrc = BASE_HL; strobes.step = STEP_DEC; strobes.wbToHl = 1'b1; end
          3'd4: strobes.baseSrc = BASE_DE;
          3'd5: strobes.baseSrc = BASE_HL;
          default: strobes.invalid = 1'b1;
        endcase
      end
      MODE_BASE: begin
        strobes.addSrc = ADD_DISP;
        unique case (reqSel[1:0])
          2'd0: strobes.baseSrc = BASE_DE;
          2'd1: strobes.baseSrc = BASE_SP;
          2'd2: strobes.baseSrc = BASE_HL;
          default: strobes.invalid = 1'b1;
        endcase
      end
      MODE_INDEX: begin
        strobes.baseSrc = BASE_WORD;
        unique case (reqSel[1:0])
          2'd0: strobes.addSrc = ADD_DE;
          2'd1: strobes.addSrc = ADD_A;
          2'd2: strobes.addSrc = ADD_HL;
          default: strobes.addSrc = ADD_B;
        endcase
      end
      default: strobes.invalid = 1'b1;
    endcase
  end

  always_comb begin
    if (strobes.step != STEP_NONE) begin
      AST_STEP_ONLY_PTR: assert (reqMode == 2'd0 && reqSel[2] == 1'b0) // R4
        else $error("step decoded outside pointer selectors 0-3");
    end
  end

endmodule

// File: rtl/eag_dpath.sv
module eag_dpath
  import eag_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  eaStrobes_t        strobes,
  input  logic [BYTE_W-1:0] regA,
  input  logic [BYTE_W-1:0] regB,
  input  logic [ADDR_W-1:0] regDE,
  input  logic [ADDR_W-1:0] regHL,
  input  logic [ADDR_W-1:0] regSP,
  input  logic [BYTE_W-1:0] disp,
  input  logic [BYTE_W-1:0] baseLo,
  input  logic [BYTE_W-1:0] baseHi,
  output logic              rspValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic              invalidSel,
  output logic              wbEn,
  output logic              wbPairHl,
  output logic [ADDR_W-1:0] wbValue
);

  localparam int PAD_W = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] baseVal;
  logic [ADDR_W-1:0] addVal;
  logic [ADDR_W-1:0] sumVal;
  logic [ADDR_W-1:0] stepVal;
  logic              doStep;

  always_comb begin
    unique case (strobes.baseSrc)
      BASE_DE:   baseVal = regDE;
      BASE_HL:   baseVal = regHL;
      BASE_SP:   baseVal = regSP;
      default:   baseVal = {baseHi, baseLo};
    endcase
    unique case (strobes.addSrc)
      ADD_DISP: addVal = {{PAD_W{1'b0}}, disp};
      ADD_A:    addVal = {{PAD_W{1'b0}}, regA};
      ADD_B:    addVal = {{PAD_W{1'b0}}, regB};
      ADD_DE:   addVal = regDE;
      ADD_HL:   addVal = regHL;
      default:  addVal = '0;
    endcase
  end

  assign sumVal  = baseVal + addVal;
  assign stepVal = (strobes.step == STEP_INC) ? baseVal + 1'b1 : baseVal - 1'b1;
  assign doStep  = (strobes.step != STEP_NONE) && !strobes.invalid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      effAddr    <= '0;
      invalidSel <= 1'b0;
      wbEn       <= 1'b0;
      wbPairHl   <= 1'b0;
      wbValue    <= '0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        effAddr    <= strobes.invalid ? '0 : sumVal;
        invalidSel <= strobes.invalid;
        wbEn       <= doStep;
        wbPairHl   <= doStep & strobes.wbToHl;
        wbValue    <= doStep ? stepVal : '0;
      end else begin
        invalidSel <= 1'b0;
        wbEn       <= 1'b0;
        wbPairHl   <= 1'b0;
        wbValue    <= '0;
      end
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid)) else $error("response without request"); // R2

  AST_WB_WITH_RSP: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> rspValid) else $error("write-back outside a response"); // R4

  AST_WB_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> (wbValue == effAddr + 1'b1 || wbValue == effAddr - 1'b1))
    else $error("write-back not one step from address"); // R4

  AST_INVALID_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    invalidSel |-> (!wbEn && effAddr == '0)) else $error("invalid request produced output"); // R7

endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqMode,
  input  logic [2:0]        reqSel,
  input  logic [BYTE_W-1:0] regA,
  input  logic [BYTE_W-1:0] regB,
  input  logic [ADDR_W-1:0] regDE,
  input  logic [ADDR_W-1:0] regHL,
  input  logic [ADDR_W-1:0] regSP,
  input  logic [BYTE_W-1:0] disp,
  input  logic [BYTE_W-1:0] baseLo,
  input  logic [BYTE_W-1:0] baseHi,
  output logic              rspValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic              invalidSel,
  output logic              wbEn,
  output logic              wbPairHl,
  output logic [ADDR_W-1:0] wbValue
);

  eaStrobes_t strobes;

  eag_ctrl ctrl_i (
    .reqMode (reqMode),
    .reqSel  (reqSel),
    .strobes (strobes)
  );

  eag_dpath #(.BYTE_W(BYTE_W)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .strobes    (strobes),
    .regA       (regA),
    .regB       (regB),
    .regDE      (regDE),
    .regHL      (regHL),
    .regSP      (regSP),
    .disp       (disp),
    .baseLo     (baseLo),
    .baseHi     (baseHi),
    .rspValid   (rspValid),
    .effAddr    (effAddr),
    .invalidSel (invalidSel),
    .wbEn       (wbEn),
    .wbPairHl   (wbPairHl),
    .wbValue    (wbValue)
  );

endmodule

// File: tb/eag_top_tb.sv
module eag_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqMode = '0;
  logic [2:0]  reqSel = '0;
  logic [7:0]  regA = '0, regB = '0, disp = '0, baseLo = '0, baseHi = '0;
  logic [15:0] regDE = '0, regHL = '0, regSP = '0;
  logic        rspValid, invalidSel, wbEn, wbPairHl;
  logic [15:0] effAddr, wbValue;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  eag_top dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode), .reqSel(reqSel),
    .regA(regA), .regB(regB), .regDE(regDE), .regHL(regHL), .regSP(regSP),
    .disp(disp), .baseLo(baseLo), .baseHi(baseHi),
    .rspValid(rspValid), .effAddr(effAddr), .invalidSel(invalidSel),
    .wbEn(wbEn), .wbPairHl(wbPairHl), .wbValue(wbValue)
  );

  task automatic judge(input string tag, input logic [50:0] act, input logic [50:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s mode=%0d sel=%0d actual=%h expected=%h", tag, reqMode, reqSel, act, exp);
    end
  endtask

  task automatic runReq(input logic [1:0] m, input logic [2:0] s);
    logic [15:0] eA, eW;
    logic        eInv, eWb, eHl;
    string       tag;
    logic [15:0] bw;
    bw = {baseHi, baseLo};
    eA = '0; eW = '0; eInv = 1'b0; eWb = 1'b0; eHl = 1'b0;
    case (m)
      2'd0: begin
        tag = (s < 3'd4) ? "R4" : (s < 3'd6) ? "R3" : "R7";
        case (s)
          3'd0: begin eA = regDE; eWb = 1; eW = regDE + 16'd1; end
          3'd1: begin eA = regHL; eWb = 1; eHl = 1; eW = regHL + 16'd1; end
          3'd2: begin eA = regDE; eWb = 1; eW = regDE - 16'd1; end
          3'd3: begin eA = regHL; eWb = 1; eHl = 1; eW = regHL - 16'd1; end
          3'd4: eA = regDE;
          3'd5: eA = regHL;
          default: eInv = 1;
        endcase
      end
      2'd1: begin
        tag = (s[1:0] == 2'd3) ? "R7" : (s[2] ? "R8" : "R5");
        case (s[1:0])
          2'd0: eA = regDE + {8'h00, disp};
          2'd1: eA = regSP + {8'h00, disp};
          2'd2: eA = regHL + {8'h00, disp};
          default: eInv = 1;
        endcase
      end
      2'd2: begin
        tag = s[2] ? "R8" : "R6";
        case (s[1:0])
          2'd0: eA = bw + regDE;
          2'd1: eA = bw + {8'h00, regA};
          2'd2: eA = bw + regHL;
          default: eA = bw + {8'h00, regB};
        endcase
      end
      default: begin tag = "R7"; eInv = 1; end
    endcase
    @(negedge clk);
    reqValid = 1'b1; reqMode = m; reqSel = s;
    @(negedge clk);
    judge(tag, {rspValid, effAddr, invalidSel, wbEn, wbPairHl, wbValue},
               {1'b1, eA, eInv, eWb, eHl, eW});
    reqValid = 1'b0;
    @(negedge clk);
    judge("R2", {33'd0, rspValid, wbEn, invalidSel, 15'd0}, 51'd0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    judge("R1", {rspValid, effAddr, invalidSel, wbEn, wbPairHl, wbValue}, 51'd0);
    rstN = 1'b1;
    @(negedge clk);
    judge("R1", {rspValid, effAddr, invalidSel, wbEn, wbPairHl, wbValue}, 51'd0);
    for (int p = 0; p < 6; p++) begin
      case (p)
        0: begin regDE = 16'h1234; regHL = 16'h8001; regSP = 16'hFE80; regA = 8'h5A; regB = 8'hC3;
                 disp = 8'h10; baseLo = 8'h00; baseHi = 8'h20; end
        1: begin regDE = 16'hFFFF; regHL = 16'h0000; regSP = 16'hFFF0; regA = 8'hFF; regB = 8'h01;
                 disp = 8'hFF; baseLo = 8'hF0; baseHi = 8'hFF; end
        2: begin regDE = 16'h0000; regHL = 16'hFFFF; regSP = 16'h0001; regA = 8'h80; regB = 8'hFF;
                 disp = 8'h80; baseLo = 8'h34; baseHi = 8'h12; end
        3: begin regDE = 16'hA5A5; regHL = 16'h5A5A; regSP = 16'h7FFF; regA = 8'h01; regB = 8'h7F;
                 disp = 8'h01; baseLo = 8'hFF; baseHi = 8'h00; end
        4: begin regDE = 16'h00FF; regHL = 16'hFF00; regSP = 16'h0100; regA = 8'h00; regB = 8'h00;
                 disp = 8'h00; baseLo = 8'h01; baseHi = 8'h80; end
        default: begin regDE = 16'h8000; regHL = 16'h7FFF; regSP = 16'hFFFF; regA = 8'hAA; regB = 8'h55;
                 disp = 8'hFE; baseLo = 8'h80; baseHi = 8'hFF; end
      endcase
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 8; s++)
          runReq(2'(m), 3'(s));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule